// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small processor and works out the word address of the next instruction on every clock edge where the core advances. It chooses among four sources:

- the sequential increment;
- a relative jump or call, which adds a signed offset to the address that follows the current one;
- a return address that an external hardware stack supplies;
- an absolute target.

Program memory is addressed in words, and all PC arithmetic wraps around the size of that memory.

The block also drives two combinational values. The first is the PC plus one, which the stack pushes on a call or an interrupt. The second is the address for a constant read from program memory. It is built from a 16-bit pointer register: the bits above bit 0 form a word address, and bit 0 picks one byte of that word. Instruction decoding, the stack and the memory itself sit outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x000 (asynchronous reset), and it stays 0x000 until the first advancing clock edge after reset is released.
- R2: On an edge with adv_i=1 and none of ret_i, abs_i, rel_i set, pc_o becomes pc_o+1 modulo 1024, so 0x3FF is followed by 0x000.
- R3: On an edge with adv_i=1, rel_i=1 and neither ret_i nor abs_i set, pc_o becomes (pc_o + k + 1) modulo 1024. Here k is rel_ofs_i read as a two's-complement number from -2048 to +2047.
- R4: On an edge with adv_i=1 and ret_i=1, pc_o becomes ret_addr_i.
- R5: On an edge with adv_i=1, abs_i=1 and ret_i=0, pc_o becomes abs_addr_i.
- R6: When several selects are high, the source is chosen in the order return, then absolute, then relative, then sequential, from highest to lowest.
- R7: push_addr_o always equals (pc_o + 1) modulo 1024, the value a call or interrupt pushes on the stack.
- R8: cst_word_o equals bits 10 down to 1 of z_i, which is the pointer shifted right by one and cut to 10 bits. cst_hi_o equals z_i bit 0: 0 selects the low byte of the word and 1 selects the high byte.
- R9: On an edge with adv_i=0, pc_o keeps its value whatever ret_i, abs_i and rel_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Load the next address on this edge |
| ret_i | input | 1 | Take the return address |
| ret_addr_i | input | 10 | Return address from the stack |
| abs_i | input | 1 | Take the absolute target |
| abs_addr_i | input | 10 | Absolute target |
| rel_i | input | 1 | Take the relative target |
| rel_ofs_i | input | 12 | Signed relative offset k |
| z_i | input | 16 | Constant-fetch pointer |
| pc_o | output | 10 | Current program counter |
| push_addr_o | output | 10 | PC+1, the value to push on a call |
| cst_word_o | output | 10 | Word address for a constant read |
| cst_hi_o | output | 1 | Byte select for a constant read: 1 selects the high byte |

## Verification
The bench builds the block with its defaults: a 10-bit PC, a 12-bit offset and a 16-bit pointer. Because the offset is wider than the PC, the offset is cut to the PC width rather than sign-extended. With these widths the extreme offsets -2048 and +2047 both carry the target past either end of memory, so the wrap paths are exercised. With a 16-bit pointer, the pointer bits above bit 10 must be dropped from the constant-fetch word address, and the bench drives patterns that check they are.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REL = 2'd1,
    SRC_ABS = 2'd2,
    SRC_RET = 2'd3
  } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
  import pc_next_pkg::*;
(
  input  logic    ret_i,
  input  logic    abs_i,
  input  logic    rel_i,
  output pc_src_e src_o
);
  // fixed priority: return > absolute > relative > sequential
  always_comb begin
    if (ret_i)      src_o = SRC_RET;
    else if (abs_i) src_o = SRC_ABS;
    else if (rel_i) src_o = SRC_REL;
    else            src_o = SRC_SEQ;
  end
endmodule

// File: rtl/pc_adder.sv
module pc_adder #(
  parameter int PC_W  = 10,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PC_W-1:0]  inc_o,
  output logic [PC_W-1:0]  rel_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] ofs_n;

  // bring offset to PC width; modulo arithmetic makes truncation exact
  generate
    if (OFS_W >= PC_W) begin : g_trunc
      assign ofs_n = ofs_i[PC_W-1:0];
      if (OFS_W > PC_W) begin : g_unused
        logic unused_ofs_hi;
        assign unused_ofs_hi = ^ofs_i[OFS_W-1:PC_W];
      end
    end else begin : g_sext
      assign ofs_n = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    end
  endgenerate

  assign inc_o = pc_i + ONE;
  assign rel_o = inc_o + ofs_n;
endmodule

// File: rtl/cst_addr_gen.sv
module cst_addr_gen #(
  parameter int PC_W = 10,
  parameter int Z_W  = 16
) (
  input  logic [Z_W-1:0]  z_i,
  output logic [PC_W-1:0] word_o,
  output logic            hi_o
);
  localparam int WBITS = Z_W - 1;

  assign hi_o = z_i[0];

  generate
    if (WBITS >= PC_W) begin : g_cut
      assign word_o = z_i[PC_W:1];
      if (WBITS > PC_W) begin : g_unused
        logic unused_z_hi;
        assign unused_z_hi = ^z_i[Z_W-1:PC_W+1];
      end
    end else begin : g_pad
      assign word_o = {{(PC_W-WBITS){1'b0}}, z_i[Z_W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int              PC_W    = 10,
  parameter int              OFS_W   = 12,
  parameter int              Z_W     = 16,
  parameter logic [PC_W-1:0] RST_VEC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             ret_i,
  input  logic [PC_W-1:0]  ret_addr_i,
  input  logic             abs_i,
  input  logic [PC_W-1:0]  abs_addr_i,
  input  logic             rel_i,
  input  logic [OFS_W-1:0] rel_ofs_i,
  input  logic [Z_W-1:0]   z_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  push_addr_o,
  output logic [PC_W-1:0]  cst_word_o,
  output logic             cst_hi_o
);
  pc_src_e         src;
  logic [PC_W-1:0] pc_q, pc_d, inc, rel_tgt;

  pc_src_arb u_arb (
    .ret_i (ret_i),
    .abs_i (abs_i),
    .rel_i (rel_i),
    .src_o (src)
  );

  pc_adder #(.PC_W(PC_W), .OFS_W(OFS_W)) u_add (
    .pc_i  (pc_q),
    .ofs_i (rel_ofs_i),
    .inc_o (inc),
    .rel_o (rel_tgt)
  );

  cst_addr_gen #(.PC_W(PC_W), .Z_W(Z_W)) u_cst (
    .z_i    (z_i),
    .word_o (cst_word_o),
    .hi_o   (cst_hi_o)
  );

  always_comb begin
    unique case (src)
      SRC_RET: pc_d = ret_addr_i;
      SRC_ABS: pc_d = abs_addr_i;
      SRC_REL: pc_d = rel_tgt;
      default: pc_d = inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= RST_VEC;
    else if (adv_i) pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign push_addr_o = inc;
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int PC_W  = 10,
  parameter int OFS_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_i,
  input logic             ret_i,
  input logic [PC_W-1:0]  ret_addr_i,
  input logic             abs_i,
  input logic [PC_W-1:0]  abs_addr_i,
  input logic             rel_i,
  input logic [OFS_W-1:0] rel_ofs_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [PC_W-1:0]  push_addr_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] k_w;
  assign k_w = PC_W'(signed'(rel_ofs_i));

  always_comb begin
    if (!rst_ni) AST_RST_PC: assert (pc_o == '0); // R1
  end

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pc_o)); // R9
  AST_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && !abs_i && !rel_i |=> pc_o == $past(pc_o) + ONE); // R2
  AST_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && rel_i && !ret_i && !abs_i |=> pc_o == $past(pc_o) + ONE + $past(k_w)); // R3
  AST_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && ret_i |=> pc_o == $past(ret_addr_i)); // R4
  AST_ABS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && abs_i && !ret_i |=> pc_o == $past(abs_addr_i)); // R5
  AST_PUSH_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ret_i && !abs_i && !rel_i |=> pc_o == $past(push_addr_o)); // R7
endmodule

bind pc_next_unit pc_next_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .adv_i       (adv_i),
  .ret_i       (ret_i),
  .ret_addr_i  (ret_addr_i),
  .abs_i       (abs_i),
  .abs_addr_i  (abs_addr_i),
  .rel_i       (rel_i),
  .rel_ofs_i   (rel_ofs_i),
  .pc_o        (pc_o),
  .push_addr_o (push_addr_o)
);

// File: tb/pc_next_unit_tb_top.sv
module pc_next_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_i = 1'b0, ret_i = 1'b0, abs_i = 1'b0, rel_i = 1'b0;
  logic [9:0]  ret_addr_i = '0, abs_addr_i = '0;
  logic [11:0] rel_ofs_i = '0;
  logic [15:0] z_i = '0;
  logic [9:0]  pc_o, push_addr_o, cst_word_o;
  logic        cst_hi_o;

  int total = 0;
  int bad   = 0;
  int exp_pc;

  always #(CLK_P/2) clk_i = ~clk_i;

  pc_next_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .ret_i(ret_i),
    .ret_addr_i(ret_addr_i), .abs_i(abs_i), .abs_addr_i(abs_addr_i),
    .rel_i(rel_i), .rel_ofs_i(rel_ofs_i), .z_i(z_i), .pc_o(pc_o),
    .push_addr_o(push_addr_o), .cst_word_o(cst_word_o), .cst_hi_o(cst_hi_o)
  );

  function automatic int wrap(input int v);
    return ((v % 1024) + 1024) % 1024;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // drive after the falling edge, sample 1 time unit after the rising edge
  task automatic step(input logic adv, input logic ret, input int ra,
                      input logic ab, input int aa, input logic rel, input int k);
    @(negedge clk_i);
    adv_i = adv; ret_i = ret; ret_addr_i = 10'(ra);
    abs_i = ab; abs_addr_i = 10'(aa); rel_i = rel; rel_ofs_i = 12'(k);
    @(posedge clk_i);
    #1;
    adv_i = 1'b0; ret_i = 1'b0; abs_i = 1'b0; rel_i = 1'b0;
  endtask

  task automatic set_pc(input int v);
    step(1'b1, 1'b0, 0, 1'b1, v, 1'b0, 0);
    exp_pc = v;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pc in reset", pc_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 pc after release, no advance", pc_o, 0);
    exp_pc = 0;
  endtask

  task automatic t_seq;
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    chk("R2 inc from 0", pc_o, 1);
    set_pc(10'h3FF);
    chk("R7 push at 0x3FF", push_addr_o, 0);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    chk("R2 wrap 0x3FF->0", pc_o, 0);
  endtask

  task automatic t_rel;
    set_pc(100);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 25);
    chk("R3 forward k=25", pc_o, wrap(100 + 25 + 1));
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, -1);
    chk("R3 k=-1 self", pc_o, 126);
    set_pc(5);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, -2048);
    chk("R3 k=-2048 wrap", pc_o, wrap(5 - 2048 + 1));
    set_pc(1000);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 2047);
    chk("R3 k=+2047 wrap", pc_o, wrap(1000 + 2047 + 1));
    set_pc(3);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, -10);
    chk("R3 k=-10 below zero", pc_o, wrap(3 - 10 + 1));
  endtask

  task automatic t_ret_abs;
    set_pc(7);
    step(1'b1, 1'b1, 10'h2A5, 1'b0, 0, 1'b0, 0);
    chk("R4 return", pc_o, 10'h2A5);
    step(1'b1, 1'b0, 0, 1'b1, 10'h155, 1'b0, 0);
    chk("R5 absolute", pc_o, 10'h155);
    chk("R7 push after abs", push_addr_o, 10'h156);
  endtask

  task automatic t_prio;
    set_pc(50);
    step(1'b1, 1'b1, 10'h011, 1'b1, 10'h022, 1'b1, 100);
    chk("R6 ret over abs+rel", pc_o, 10'h011);
    step(1'b1, 1'b0, 0, 1'b1, 10'h033, 1'b1, 100);
    chk("R6 abs over rel", pc_o, 10'h033);
    step(1'b1, 1'b0, 0, 1'b0, 0, 1'b1, 4);
    chk("R6 rel over seq", pc_o, 10'h033 + 5);
  endtask

  task automatic t_hold;
    set_pc(200);
    step(1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    chk("R9 hold no selects", pc_o, 200);
    step(1'b0, 1'b1, 10'h3F0, 1'b1, 10'h0F0, 1'b1, 300);
    chk("R9 hold all selects", pc_o, 200);
    chk("R7 push while held", push_addr_o, 201);
  endtask

  task automatic t_cst;
    @(negedge clk_i); z_i = 16'h0000; #1;
    chk("R8 word z=0", cst_word_o, 0);
    chk("R8 lo byte z=0", cst_hi_o, 0);
    @(negedge clk_i); z_i = 16'h07FF; #1;
    chk("R8 word z=0x7FF", cst_word_o, 10'h3FF);
    chk("R8 hi byte z=0x7FF", cst_hi_o, 1);
    @(negedge clk_i); z_i = 16'hF802; #1;
    chk("R8 word top bits dropped", cst_word_o, 1);
    chk("R8 lo byte z=0xF802", cst_hi_o, 0);
    @(negedge clk_i); z_i = 16'h0A55; #1;
    chk("R8 word z=0xA55", cst_word_o, (16'h0A55 >> 1) % 1024);
    chk("R8 hi byte z=0xA55", cst_hi_o, 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_seq();
    t_rel();
    t_ret_abs();
    t_prio();
    t_hold();
    t_cst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule